// File: doc/BRIEF.md
# Variable-Length Program Counter Unit

This block holds the code address of a small processor whose instructions are encoded in bytes. It keeps a 16-bit fetch address. Once an instruction has finished, the address moves forward by that instruction's size of one, two or three bytes. For a branch, jump, call, return or interrupt vector, a target address is loaded in its place. Instruction decode, memory fetch and the saving of return addresses happen elsewhere.

The sequencer drives four things: a two-bit length code, an advance strobe, a load strobe with its target, and a synchronous active-low reset. The block presents the current fetch address. Alongside it, a combinational output gives the current address plus the length of the instruction. A call sequence saves that value as its return address.

Top module: `prog_counter_unit`

## Requirements
- R1: When rst_n is sampled low at a rising clock edge, pc_q is 0x0000 after that edge, whatever the other inputs are.
- R2: With load low, adv high and len_code 01, 10 or 11, pc_q rises by 1, 2 or 3 respectively at the next rising edge.
- R3: With load low and adv high, len_code 00 leaves pc_q unchanged across the edge.
- R4: With both adv and load low, pc_q keeps its value across the edge, whatever len_code is.
- R5: With load high, pc_q equals the load_addr value sampled at the next rising edge.
- R6: When load and adv are both high, the load takes priority: pc_q becomes load_addr and no increment is applied.
- R7: An advance past 0xFFFF wraps modulo 65536 and raises no flag. For example, 0xFFFE advanced by 3 gives 0x0001.
- R8: pc_seq equals pc_q plus the byte count of len_code, modulo 65536, in the same cycle (len_code 00 adds 0). It does not depend on adv or load.
- R9: Reset takes priority over load and advance asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| len_code | input | 2 | Length of the instruction just executed: 00 hold, 01 one byte, 10 two bytes, 11 three bytes |
| adv | input | 1 | Advance by len_code at the next edge |
| load | input | 1 | Load load_addr at the next edge |
| load_addr | input | 16 | Non-sequential target address |
| pc_q | output | 16 | Current fetch address |
| pc_seq | output | 16 | Current address plus length, usable as return address |

## Verification
The properties assume that every input is known and stable at each rising edge. They also assume that reset is applied once before the outputs are judged. Inputs may combine in any way, including load and adv together and a zero length code with adv high, so no property excludes those combinations. The stimulus changes inputs only on falling edges. It first holds reset for a cycle, and then covers every length code, overlapping strobes, loads near the top of the address space and reset with both strobes active.

// File: rtl/pcu_pkg.sv
// Package pcu_pkg
// Shared encodings for the program counter unit. The length code encoding
// is fixed by the interface to the instruction sequencer.
package pcu_pkg;

    localparam int unsigned LEN_W = 2;

    // Byte count of the instruction just executed; HOLD means no step.
    typedef enum logic [LEN_W-1:0] {
        LEN_HOLD  = 2'b00,
        LEN_ONE   = 2'b01,
        LEN_TWO   = 2'b10,
        LEN_THREE = 2'b11
    } len_code_e;

    // Source chosen for the next counter value.
    typedef enum logic [1:0] {
        SRC_KEEP = 2'b00,
        SRC_STEP = 2'b01,
        SRC_LOAD = 2'b10
    } next_src_e;

endpackage

// File: rtl/pcu_len_decode.sv
// Module pcu_len_decode
// Turns the two-bit length code into a zero-extended byte step of the
// address width. Assumes ADDR_W is wider than the length code.
module pcu_len_decode #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [pcu_pkg::LEN_W-1:0] len_code,
    output logic [ADDR_W-1:0]         step_bytes
);
    import pcu_pkg::*;

    localparam int unsigned PAD_W = ADDR_W - LEN_W;

    logic [LEN_W-1:0] count;

    // Map each code onto its byte count.
    always_comb begin
        case (len_code)
            LEN_ONE:   count = 2'd1;
            LEN_TWO:   count = 2'd2;
            LEN_THREE: count = 2'd3;
            default:   count = 2'd0;
        endcase
    end

    // Extend the count to the full address width.
    assign step_bytes = {{PAD_W{1'b0}}, count};

endmodule

// File: rtl/pcu_wrap_adder.sv
// Module pcu_wrap_adder
// Modulo-2^W adder. The carry out of the top bit is dropped, so the sum
// wraps. RIPPLE picks an explicit carry chain; otherwise the operator form
// is used. Assumes W >= 2.
module pcu_wrap_adder #(
    parameter int unsigned W      = 16,
    parameter bit          RIPPLE = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);

    generate
        if (RIPPLE) begin : g_ripple
            logic [W-1:0] carry;
            assign carry[0] = 1'b0;
            for (genvar i = 0; i < W; i++) begin : g_bit
                // Sum bit for position i.
                assign sum[i] = a[i] ^ b[i] ^ carry[i];
                if (i < W - 1) begin : g_carry
                    // Carry into the next position; top carry discarded.
                    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
                end
            end
        end else begin : g_operator
            // Width-truncated addition wraps naturally.
            assign sum = a + b;
        end
    endgenerate

endmodule

// File: rtl/pcu_next_select.sv
// Module pcu_next_select
// Chooses the next counter value with fixed priority: load, then step,
// then keep. A step with the hold code counts as keep. Reset is applied
// in the register, not here.
module pcu_next_select #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic                      load,
    input  logic                      adv,
    input  logic [pcu_pkg::LEN_W-1:0] len_code,
    input  logic [ADDR_W-1:0]         cur_pc,
    input  logic [ADDR_W-1:0]         target,
    input  logic [ADDR_W-1:0]         stepped,
    output logic [ADDR_W-1:0]         next_pc
);
    import pcu_pkg::*;

    next_src_e src;

    // Priority decision for the next source.
    always_comb begin
        if (load) begin
            src = SRC_LOAD;
        end else if (adv && (len_code != LEN_HOLD)) begin
            src = SRC_STEP;
        end else begin
            src = SRC_KEEP;
        end
    end

    // Data mux driven by the decision.
    always_comb begin
        case (src)
            SRC_LOAD: next_pc = target;
            SRC_STEP: next_pc = stepped;
            default:  next_pc = cur_pc;
        endcase
    end

endmodule

// File: rtl/prog_counter_unit.sv
// Module prog_counter_unit
// Program counter for byte-coded instructions of 1 to 3 bytes. It advances
// after an instruction by its length or loads a new target; a load beats
// an advance. pc_seq gives pc_q plus the length at once, as a return
// address. Assumes inputs settle before each rising edge; reset is
// synchronous and active low.
module prog_counter_unit #(
    parameter int unsigned ADDR_W = 16,
    parameter bit          RIPPLE = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [pcu_pkg::LEN_W-1:0] len_code,
    input  logic                      adv,
    input  logic                      load,
    input  logic [ADDR_W-1:0]         load_addr,
    output logic [ADDR_W-1:0]         pc_q,
    output logic [ADDR_W-1:0]         pc_seq
);

    localparam logic [ADDR_W-1:0] RESET_PC = '0;

    logic [ADDR_W-1:0] step_bytes;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] next_pc;
    logic [ADDR_W-1:0] pc_r;

    pcu_len_decode #(
        .ADDR_W (ADDR_W)
    ) u_len_decode (
        .len_code   (len_code),
        .step_bytes (step_bytes)
    );

    pcu_wrap_adder #(
        .W      (ADDR_W),
        .RIPPLE (RIPPLE)
    ) u_adder (
        .a   (pc_r),
        .b   (step_bytes),
        .sum (seq_addr)
    );

    pcu_next_select #(
        .ADDR_W (ADDR_W)
    ) u_next_select (
        .load     (load),
        .adv      (adv),
        .len_code (len_code),
        .cur_pc   (pc_r),
        .target   (load_addr),
        .stepped  (seq_addr),
        .next_pc  (next_pc)
    );

    // Counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_r <= RESET_PC;
        end else begin
            pc_r <= next_pc;
        end
    end

    assign pc_q   = pc_r;
    assign pc_seq = seq_addr;

endmodule

// File: rtl/prog_counter_unit_checker.sv
// Module prog_counter_unit_checker
// Temporal properties of the program counter unit, checked at its ports.
// Bound to every prog_counter_unit instance.
module prog_counter_unit_checker #(
    parameter int unsigned ADDR_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [pcu_pkg::LEN_W-1:0] len_code,
    input logic                      adv,
    input logic                      load,
    input logic [ADDR_W-1:0]         load_addr,
    input logic [ADDR_W-1:0]         pc_q,
    input logic [ADDR_W-1:0]         pc_seq
);

    logic seen_rst = 1'b0;

    // Remember that a reset has been sampled at least once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rst <= 1'b1;
        end
    end

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && $past(!rst_n)) |-> (pc_q == '0));

    // Also covers R7: the adder output wraps and the counter follows it.
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && adv && !load && len_code != 2'b00) |=> (pc_q == $past(pc_seq)));

    p_zero_len_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && adv && !load && len_code == 2'b00) |=> $stable(pc_q));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && !adv && !load) |=> $stable(pc_q));

    // Also covers R6: no adv condition in the antecedent.
    p_load_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && load) |=> (pc_q == $past(load_addr)));

    p_seq_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_rst |-> ((pc_seq - pc_q) == ADDR_W'(len_code)));

endmodule

bind prog_counter_unit prog_counter_unit_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/prog_counter_unit_bench.sv
// Scoreboard bench: the driver computes the expected counter value and
// queues it; the monitor pops it after each rising edge and compares it.
module prog_counter_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  len_code = 2'b00;
    logic        adv = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_addr = 16'h0000;
    logic [15:0] pc_q;
    logic [15:0] pc_seq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] model_pc = 16'h0000;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    prog_counter_unit u_prog_counter_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_code  (len_code),
        .adv       (adv),
        .load      (load),
        .load_addr (load_addr),
        .pc_q      (pc_q),
        .pc_seq    (pc_seq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: one queued expectation per edge, sampled 1 time unit later.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pc_q !== e) begin
                errors++;
                $display("FAIL %s pc_q actual %h expected %h", t, pc_q, e);
            end
        end
    end

    // Driver: apply one cycle of inputs at the falling edge, check pc_seq,
    // and queue the counter value expected after the next rising edge.
    task automatic drive(input logic r, input logic a, input logic l,
                         input logic [1:0] len, input logic [15:0] tgt,
                         input string tag);
        logic [15:0] seq_exp;
        @(negedge clk);
        rst_n = r; adv = a; load = l; len_code = len; load_addr = tgt;
        #1;
        if (r) begin
            seq_exp = model_pc + 16'(len);
            checks++;
            if (pc_seq !== seq_exp) begin
                errors++;
                $display("FAIL R8 pc_seq actual %h expected %h", pc_seq, seq_exp);
            end
        end
        if (!r)          model_pc = 16'h0000;
        else if (l)      model_pc = tgt;
        else if (a)      model_pc = model_pc + 16'(len);
        exp_q.push_back(model_pc);
        tag_q.push_back(tag);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        drive(1'b0, 1'b0, 1'b0, 2'b00, 16'h0000, "R1");
        drive(1'b1, 1'b1, 1'b0, 2'b01, 16'h0000, "R2 len1");
        drive(1'b1, 1'b1, 1'b0, 2'b10, 16'h0000, "R2 len2");
        drive(1'b1, 1'b1, 1'b0, 2'b11, 16'h0000, "R2 len3");
        drive(1'b1, 1'b1, 1'b0, 2'b00, 16'h0000, "R3");
        drive(1'b1, 1'b0, 1'b0, 2'b11, 16'h0000, "R4 len3");
        drive(1'b1, 1'b0, 1'b0, 2'b01, 16'h5555, "R4 len1");
        drive(1'b1, 1'b0, 1'b1, 2'b00, 16'h1234, "R5");
        drive(1'b1, 1'b1, 1'b0, 2'b10, 16'h0000, "R2 after load");
        drive(1'b1, 1'b1, 1'b1, 2'b11, 16'hABCD, "R6");
        drive(1'b1, 1'b0, 1'b0, 2'b10, 16'h0000, "R4 after R6");
        drive(1'b1, 1'b0, 1'b1, 2'b00, 16'hFFFE, "R5 top");
        drive(1'b1, 1'b1, 1'b0, 2'b11, 16'h0000, "R7 FFFE+3");
        drive(1'b1, 1'b0, 1'b1, 2'b01, 16'hFFFF, "R5 FFFF");
        drive(1'b1, 1'b1, 1'b0, 2'b01, 16'h0000, "R7 FFFF+1");
        drive(1'b1, 1'b0, 1'b1, 2'b00, 16'hFFFD, "R5 FFFD");
        drive(1'b1, 1'b1, 1'b0, 2'b10, 16'h0000, "R7 FFFD+2");
        drive(1'b1, 1'b1, 1'b0, 2'b11, 16'h0000, "R2 from FFFF");
        drive(1'b1, 1'b0, 1'b1, 2'b00, 16'h7F00, "R5 mid");
        drive(1'b0, 1'b1, 1'b1, 2'b11, 16'h4321, "R9");
        drive(1'b1, 1'b1, 1'b0, 2'b11, 16'h0000, "R2 after R9");
        drive(1'b1, 1'b0, 1'b0, 2'b00, 16'h0000, "R4 final");
        @(negedge clk);
        adv = 1'b0; load = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        report();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        report();
    end

endmodule